// File: doc/BRIEF.md
# Squash and Redirect Generator

This block lives in the execute stage of a multithreaded out-of-order core. Every cycle it receives, for each hardware thread, up to three squash triggers from resolved instructions: a mispredicted branch, a load/store ordering violation and a load that could not proceed because memory was blocked. It keeps at most one of them per thread and, one clock later, presents a complete squash request to the commit stage. The request carries the sequence number to squash from, whether that instruction is itself discarded, the PC at which fetch resumes, and for branches the mispredicted PC, a taken indication and a delay-slot discard flag.

Restart-address selection honours architectural branch delay slots when the `DELAY_SLOT` parameter is set, and falls back to a plain next-PC restart when it is clear. A blocked-load squash that wins its thread also returns a one-cycle acknowledge toward the load/store queue. Three event counters record mispredicts of branches predicted taken, mispredicts of branches predicted not taken, and ordering violations.

Top module: `squash_redirect_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every request output, every acknowledge and all three counters are zero.
- R2: A mispredict on thread t in cycle n gives, in cycle n+1, squash=1, squash sequence number = the branch's, mispredict PC = the branch PC, branch flag=1, include flag=0, acknowledge=0.
- R3: With delay slots, the taken flag is 1 exactly when the branch's next-next PC differs from both PC+8 and PC+12 (4-byte instructions).
- R4: With delay slots, the delay slot is discarded (flag=1) when the next PC differs from PC+4; the restart PC is then the next PC, otherwise the next-next PC.
- R5: Without delay slots, the taken flag is 1 when the next PC differs from PC+4, the restart PC is the next PC and the delay-slot flag is 0.
- R6: An ordering violation gives squash=1, its sequence number, restart PC = the violating instruction's next PC, include=0, branch flag=0, taken=0, delay-slot flag=0, mispredict PC=0.
- R7: A blocked load gives squash=1, include=1, restart PC = the load's own PC and acknowledge=1 for exactly that one cycle.
- R8: Per thread a mispredict beats an ordering violation, which beats a blocked load; a losing trigger changes no output, gives no acknowledge and is not counted.
- R9: Each thread's request depends only on that thread's triggers.
- R10: Each counter adds, per cycle, the number of threads whose winning trigger is of its kind (mispredict predicted taken, mispredict predicted not taken, ordering violation).
- R11: A thread with no trigger in cycle n shows squash=0 and all request fields zero in cycle n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bm_vld_i | input | NUM_THREADS | Mispredicted branch present, per thread |
| bm_pred_taken_i | input | NUM_THREADS | That branch had been predicted taken |
| bm_seq_i | input | NUM_THREADS*16 | Branch sequence numbers |
| bm_pc_i | input | NUM_THREADS*32 | Branch PCs |
| bm_npc_i | input | NUM_THREADS*32 | Branch resolved next PCs |
| bm_nnpc_i | input | NUM_THREADS*32 | Branch resolved next-next PCs |
| mo_vld_i | input | NUM_THREADS | Ordering violation present, per thread |
| mo_seq_i | input | NUM_THREADS*16 | Sequence numbers of the violating instructions |
| mo_npc_i | input | NUM_THREADS*32 | Next PCs of the violating instructions |
| lb_vld_i | input | NUM_THREADS | Blocked load present, per thread |
| lb_seq_i | input | NUM_THREADS*16 | Blocked load sequence numbers |
| lb_pc_i | input | NUM_THREADS*32 | Blocked load PCs |
| sq_vld_o | output | NUM_THREADS | Squash request |
| sq_seq_o | output | NUM_THREADS*16 | Sequence number to squash from |
| sq_incl_o | output | NUM_THREADS | That instruction is squashed too |
| sq_pc_o | output | NUM_THREADS*32 | Restart PC |
| sq_mispc_o | output | NUM_THREADS*32 | Mispredicted branch PC |
| sq_brmis_o | output | NUM_THREADS | Request caused by a mispredict |
| sq_taken_o | output | NUM_THREADS | Branch resolved taken |
| sq_dsq_o | output | NUM_THREADS | Delay slot discarded |
| lb_ack_o | output | NUM_THREADS | Blocked-load handled pulse |
| cnt_pt_o | output | CNT_W | Mispredicts predicted taken |
| cnt_pnt_o | output | CNT_W | Mispredicts predicted not taken |
| cnt_mo_o | output | CNT_W | Ordering violations |

## Verification
The hardest situation to reach is several triggers landing on the same thread in one cycle while the other thread carries a different one, since only then can arbitration, the suppressed acknowledge and the uncounted losers be seen. The bench drives all three triggers on one thread and two on the other in a single cycle, then checks that only the winners appear and that the counters moved by the winners alone. A second instance built without delay slots shares every input, so each branch pattern checks both restart rules at once, including next-next PCs placed exactly on the PC+8 and PC+12 boundaries.

// File: rtl/squash_redirect_pkg.sv
package squash_redirect_pkg;

  localparam int SRG_PC_W  = 32;
  localparam int SRG_SEQ_W = 16;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_BRANCH = 2'd1,
    CAUSE_MEMORD = 2'd2,
    CAUSE_LDBLK  = 2'd3
  } sq_cause_e;

  typedef struct packed {
    logic                 vld;
    logic                 incl;
    logic                 brmis;
    logic                 taken;
    logic                 dsq;
    logic                 ack;
    logic [SRG_SEQ_W-1:0] seq;
    logic [SRG_PC_W-1:0]  pc;
    logic [SRG_PC_W-1:0]  mispc;
  } sq_req_t;

endpackage

// File: rtl/srg_branch_eval.sv
module srg_branch_eval
  import squash_redirect_pkg::*;
#(
  parameter bit DELAY_SLOT = 1'b1,
  parameter int INST_BYTES = 4
) (
  input  logic [SRG_PC_W-1:0] pc_i,
  input  logic [SRG_PC_W-1:0] npc_i,
  input  logic [SRG_PC_W-1:0] nnpc_i,
  output logic                taken_o,
  output logic                dsq_o,
  output logic [SRG_PC_W-1:0] restart_o
);

  localparam logic [SRG_PC_W-1:0] STEP1 = SRG_PC_W'(INST_BYTES);
  localparam logic [SRG_PC_W-1:0] STEP2 = SRG_PC_W'(2 * INST_BYTES);
  localparam logic [SRG_PC_W-1:0] STEP3 = SRG_PC_W'(3 * INST_BYTES);

  logic seq_fall;
  assign seq_fall = (npc_i == pc_i + STEP1);

  generate
    if (DELAY_SLOT) begin : g_ds
      logic nn_seq2, nn_seq3;
      always_comb begin
        nn_seq2   = (nnpc_i == pc_i + STEP2);
        nn_seq3   = (nnpc_i == pc_i + STEP3);
        taken_o   = !nn_seq2 && !nn_seq3;
        dsq_o     = !seq_fall;
        restart_o = dsq_o ? npc_i : nnpc_i;
      end
    end else begin : g_nods
      logic unused_nnpc;
      assign unused_nnpc = ^nnpc_i;
      always_comb begin
        taken_o   = !seq_fall;
        dsq_o     = 1'b0;
        restart_o = npc_i;
      end
    end
  endgenerate

endmodule

// File: rtl/srg_thread_sel.sv
module srg_thread_sel
  import squash_redirect_pkg::*;
(
  input  logic                 bm_vld_i,
  input  logic [SRG_SEQ_W-1:0] bm_seq_i,
  input  logic [SRG_PC_W-1:0]  bm_pc_i,
  input  logic                 bm_taken_i,
  input  logic                 bm_dsq_i,
  input  logic [SRG_PC_W-1:0]  bm_restart_i,
  input  logic                 mo_vld_i,
  input  logic [SRG_SEQ_W-1:0] mo_seq_i,
  input  logic [SRG_PC_W-1:0]  mo_npc_i,
  input  logic                 lb_vld_i,
  input  logic [SRG_SEQ_W-1:0] lb_seq_i,
  input  logic [SRG_PC_W-1:0]  lb_pc_i,
  output sq_req_t              req_o,
  output sq_cause_e            cause_o
);

  // Redirect flag starts clear every cycle; the first trigger in rank
  // order sets it and masks the rest.
  logic redirected;

  always_comb begin
    req_o      = '0;
    cause_o    = CAUSE_NONE;
    redirected = 1'b0;
    if (!redirected && bm_vld_i) begin
      redirected  = 1'b1;
      cause_o     = CAUSE_BRANCH;
      req_o.vld   = 1'b1;
      req_o.brmis = 1'b1;
      req_o.seq   = bm_seq_i;
      req_o.mispc = bm_pc_i;
      req_o.taken = bm_taken_i;
      req_o.dsq   = bm_dsq_i;
      req_o.pc    = bm_restart_i;
    end
    if (!redirected && mo_vld_i) begin
      redirected  = 1'b1;
      cause_o     = CAUSE_MEMORD;
      req_o.vld   = 1'b1;
      req_o.seq   = mo_seq_i;
      req_o.pc    = mo_npc_i;
    end
    if (!redirected && lb_vld_i) begin
      redirected  = 1'b1;
      cause_o     = CAUSE_LDBLK;
      req_o.vld   = 1'b1;
      req_o.incl  = 1'b1;
      req_o.ack   = 1'b1;
      req_o.seq   = lb_seq_i;
      req_o.pc    = lb_pc_i;
    end
  end

endmodule

// File: rtl/srg_event_count.sv
module srg_event_count #(
  parameter int NUM_THREADS = 2,
  parameter int CNT_W       = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] inc_i,
  output logic [CNT_W-1:0]       cnt_o
);

  logic [CNT_W-1:0] add_amt;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    add_amt = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      add_amt = add_amt + CNT_W'(inc_i[t]);
    end
    cnt_en = |inc_i;
    cnt_d  = cnt_o + add_amt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (cnt_en) begin
      cnt_o <= cnt_d;
    end
  end

  // R10: never advances by more than one per thread in a cycle
  a_r10_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(cnt_o - $past(cnt_o)) <= CNT_W'(NUM_THREADS)));

endmodule

// File: rtl/squash_redirect_gen.sv
module squash_redirect_gen
  import squash_redirect_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter bit DELAY_SLOT  = 1'b1,
  parameter int INST_BYTES  = 4,
  parameter int CNT_W       = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_THREADS-1:0]           bm_vld_i,
  input  logic [NUM_THREADS-1:0]           bm_pred_taken_i,
  input  logic [NUM_THREADS*SRG_SEQ_W-1:0] bm_seq_i,
  input  logic [NUM_THREADS*SRG_PC_W-1:0]  bm_pc_i,
  input  logic [NUM_THREADS*SRG_PC_W-1:0]  bm_npc_i,
  input  logic [NUM_THREADS*SRG_PC_W-1:0]  bm_nnpc_i,
  input  logic [NUM_THREADS-1:0]           mo_vld_i,
  input  logic [NUM_THREADS*SRG_SEQ_W-1:0] mo_seq_i,
  input  logic [NUM_THREADS*SRG_PC_W-1:0]  mo_npc_i,
  input  logic [NUM_THREADS-1:0]           lb_vld_i,
  input  logic [NUM_THREADS*SRG_SEQ_W-1:0] lb_seq_i,
  input  logic [NUM_THREADS*SRG_PC_W-1:0]  lb_pc_i,
  output logic [NUM_THREADS-1:0]           sq_vld_o,
  output logic [NUM_THREADS*SRG_SEQ_W-1:0] sq_seq_o,
  output logic [NUM_THREADS-1:0]           sq_incl_o,
  output logic [NUM_THREADS*SRG_PC_W-1:0]  sq_pc_o,
  output logic [NUM_THREADS*SRG_PC_W-1:0]  sq_mispc_o,
  output logic [NUM_THREADS-1:0]           sq_brmis_o,
  output logic [NUM_THREADS-1:0]           sq_taken_o,
  output logic [NUM_THREADS-1:0]           sq_dsq_o,
  output logic [NUM_THREADS-1:0]           lb_ack_o,
  output logic [CNT_W-1:0]                 cnt_pt_o,
  output logic [CNT_W-1:0]                 cnt_pnt_o,
  output logic [CNT_W-1:0]                 cnt_mo_o
);

  localparam int PW = SRG_PC_W;
  localparam int SW = SRG_SEQ_W;

  sq_req_t                req_d [NUM_THREADS];
  sq_req_t                req_q [NUM_THREADS];
  sq_cause_e              cause [NUM_THREADS];
  logic [NUM_THREADS-1:0] inc_pt, inc_pnt, inc_mo;

  genvar t;
  generate
    for (t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic          br_taken, br_dsq;
      logic [PW-1:0] br_restart;

      srg_branch_eval #(
        .DELAY_SLOT (DELAY_SLOT),
        .INST_BYTES (INST_BYTES)
      ) u_beval (
        .pc_i      (bm_pc_i[t*PW +: PW]),
        .npc_i     (bm_npc_i[t*PW +: PW]),
        .nnpc_i    (bm_nnpc_i[t*PW +: PW]),
        .taken_o   (br_taken),
        .dsq_o     (br_dsq),
        .restart_o (br_restart)
      );

      srg_thread_sel u_sel (
        .bm_vld_i     (bm_vld_i[t]),
        .bm_seq_i     (bm_seq_i[t*SW +: SW]),
        .bm_pc_i      (bm_pc_i[t*PW +: PW]),
        .bm_taken_i   (br_taken),
        .bm_dsq_i     (br_dsq),
        .bm_restart_i (br_restart),
        .mo_vld_i     (mo_vld_i[t]),
        .mo_seq_i     (mo_seq_i[t*SW +: SW]),
        .mo_npc_i     (mo_npc_i[t*PW +: PW]),
        .lb_vld_i     (lb_vld_i[t]),
        .lb_seq_i     (lb_seq_i[t*SW +: SW]),
        .lb_pc_i      (lb_pc_i[t*PW +: PW]),
        .req_o        (req_d[t]),
        .cause_o      (cause[t])
      );

      always_comb begin
        inc_pt[t]  = (cause[t] == CAUSE_BRANCH) &&  bm_pred_taken_i[t];
        inc_pnt[t] = (cause[t] == CAUSE_BRANCH) && !bm_pred_taken_i[t];
        inc_mo[t]  = (cause[t] == CAUSE_MEMORD);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          req_q[t] <= '0;
        end else begin
          req_q[t] <= req_d[t];
        end
      end

      assign sq_vld_o[t]               = req_q[t].vld;
      assign sq_seq_o[t*SW +: SW]      = req_q[t].seq;
      assign sq_incl_o[t]              = req_q[t].incl;
      assign sq_pc_o[t*PW +: PW]       = req_q[t].pc;
      assign sq_mispc_o[t*PW +: PW]    = req_q[t].mispc;
      assign sq_brmis_o[t]             = req_q[t].brmis;
      assign sq_taken_o[t]             = req_q[t].taken;
      assign sq_dsq_o[t]               = req_q[t].dsq;
      assign lb_ack_o[t]               = req_q[t].ack;

      // R7: an acknowledge only travels with an inclusive, non-branch squash
      a_r7_ack_inclusive: assert property (@(posedge clk) disable iff (!rst_n)
        lb_ack_o[t] |-> (sq_vld_o[t] && sq_incl_o[t] && !sq_brmis_o[t]));

      // R4: delay-slot discard is a branch-only attribute
      a_r4_dsq_needs_branch: assert property (@(posedge clk) disable iff (!rst_n)
        sq_dsq_o[t] |-> sq_brmis_o[t]);

      // R8: a mispredict always wins its thread one cycle later
      a_r8_branch_wins: assert property (@(posedge clk) disable iff (!rst_n)
        bm_vld_i[t] |=> (sq_brmis_o[t] && !lb_ack_o[t]));

      // R11: no trigger, no request next cycle
      a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(bm_vld_i[t] || mo_vld_i[t] || lb_vld_i[t]) |=> !sq_vld_o[t]);
    end
  endgenerate

  srg_event_count #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W)) u_cnt_pt (
    .clk (clk), .rst_n (rst_n), .inc_i (inc_pt), .cnt_o (cnt_pt_o));

  srg_event_count #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W)) u_cnt_pnt (
    .clk (clk), .rst_n (rst_n), .inc_i (inc_pnt), .cnt_o (cnt_pnt_o));

  srg_event_count #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W)) u_cnt_mo (
    .clk (clk), .rst_n (rst_n), .inc_i (inc_mo), .cnt_o (cnt_mo_o));

endmodule

// File: tb/squash_redirect_gen_tb_top.sv
module squash_redirect_gen_tb_top;

  localparam int NT = 2;
  localparam int PW = 32;
  localparam int SW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic [NT-1:0]    bm_vld, bm_pt, mo_vld, lb_vld;
  logic [NT*SW-1:0] bm_seq, mo_seq, lb_seq;
  logic [NT*PW-1:0] bm_pc, bm_npc, bm_nnpc, mo_npc, lb_pc;

  logic [NT-1:0]    a_vld, a_incl, a_brmis, a_taken, a_dsq, a_ack;
  logic [NT*SW-1:0] a_seq;
  logic [NT*PW-1:0] a_pc, a_mispc;
  logic [CW-1:0]    a_cpt, a_cpnt, a_cmo;

  logic [NT-1:0]    b_vld, b_incl, b_brmis, b_taken, b_dsq, b_ack;
  logic [NT*SW-1:0] b_seq;
  logic [NT*PW-1:0] b_pc, b_mispc;
  logic [CW-1:0]    b_cpt, b_cpnt, b_cmo;

  squash_redirect_gen #(.NUM_THREADS(NT), .DELAY_SLOT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .bm_vld_i(bm_vld), .bm_pred_taken_i(bm_pt), .bm_seq_i(bm_seq),
    .bm_pc_i(bm_pc), .bm_npc_i(bm_npc), .bm_nnpc_i(bm_nnpc),
    .mo_vld_i(mo_vld), .mo_seq_i(mo_seq), .mo_npc_i(mo_npc),
    .lb_vld_i(lb_vld), .lb_seq_i(lb_seq), .lb_pc_i(lb_pc),
    .sq_vld_o(a_vld), .sq_seq_o(a_seq), .sq_incl_o(a_incl), .sq_pc_o(a_pc),
    .sq_mispc_o(a_mispc), .sq_brmis_o(a_brmis), .sq_taken_o(a_taken),
    .sq_dsq_o(a_dsq), .lb_ack_o(a_ack),
    .cnt_pt_o(a_cpt), .cnt_pnt_o(a_cpnt), .cnt_mo_o(a_cmo));

  squash_redirect_gen #(.NUM_THREADS(NT), .DELAY_SLOT(1'b0)) dut_nd_i (
    .clk(clk), .rst_n(rst_n),
    .bm_vld_i(bm_vld), .bm_pred_taken_i(bm_pt), .bm_seq_i(bm_seq),
    .bm_pc_i(bm_pc), .bm_npc_i(bm_npc), .bm_nnpc_i(bm_nnpc),
    .mo_vld_i(mo_vld), .mo_seq_i(mo_seq), .mo_npc_i(mo_npc),
    .lb_vld_i(lb_vld), .lb_seq_i(lb_seq), .lb_pc_i(lb_pc),
    .sq_vld_o(b_vld), .sq_seq_o(b_seq), .sq_incl_o(b_incl), .sq_pc_o(b_pc),
    .sq_mispc_o(b_mispc), .sq_brmis_o(b_brmis), .sq_taken_o(b_taken),
    .sq_dsq_o(b_dsq), .lb_ack_o(b_ack),
    .cnt_pt_o(b_cpt), .cnt_pnt_o(b_cpnt), .cnt_mo_o(b_cmo));

  int checks = 0;
  int errors = 0;
  int exp_pt = 0, exp_pnt = 0, exp_mo = 0;
  bit done = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    bm_vld = '0; bm_pt = '0; mo_vld = '0; lb_vld = '0;
    bm_seq = '0; mo_seq = '0; lb_seq = '0;
    bm_pc = '0; bm_npc = '0; bm_nnpc = '0; mo_npc = '0; lb_pc = '0;
  endtask

  task automatic set_br(int t, logic pt, logic [15:0] sq, logic [31:0] pc,
                        logic [31:0] npc, logic [31:0] nnpc);
    bm_vld[t] = 1'b1; bm_pt[t] = pt; bm_seq[t*SW +: SW] = sq;
    bm_pc[t*PW +: PW] = pc; bm_npc[t*PW +: PW] = npc; bm_nnpc[t*PW +: PW] = nnpc;
  endtask

  task automatic check_idle(string req, int t);
    chk(req, "vld",   32'(a_vld[t]), 0);
    chk(req, "pc",    a_pc[t*PW +: PW], 0);
    chk(req, "seq",   32'(a_seq[t*SW +: SW]), 0);
    chk(req, "ack",   32'(a_ack[t]), 0);
    chk(req, "nd_vld", 32'(b_vld[t]), 0);
  endtask

  task automatic check_cnt(string req);
    chk(req, "cnt_pt",  32'(a_cpt),  32'(exp_pt));
    chk(req, "cnt_pnt", 32'(a_cpnt), 32'(exp_pnt));
    chk(req, "cnt_mo",  32'(a_cmo),  32'(exp_mo));
    chk(req, "nd_cnt_pt", 32'(b_cpt), 32'(exp_pt));
    chk(req, "nd_cnt_mo", 32'(b_cmo), 32'(exp_mo));
  endtask

  // One mispredict on thread t; expected values for both builds.
  task automatic t_branch(int t, logic pt, logic [15:0] sq, logic [31:0] pc,
                          logic [31:0] npc, logic [31:0] nnpc,
                          logic ds_tk, logic ds_dsq, logic [31:0] ds_rs,
                          logic nd_tk);
    @(negedge clk);
    clear_in();
    set_br(t, pt, sq, pc, npc, nnpc);
    if (pt) exp_pt++; else exp_pnt++;
    @(negedge clk);
    chk("R2", "vld",   32'(a_vld[t]), 1);
    chk("R2", "seq",   32'(a_seq[t*SW +: SW]), 32'(sq));
    chk("R2", "mispc", a_mispc[t*PW +: PW], pc);
    chk("R2", "brmis", 32'(a_brmis[t]), 1);
    chk("R2", "incl",  32'(a_incl[t]), 0);
    chk("R2", "ack",   32'(a_ack[t]), 0);
    chk("R3", "taken", 32'(a_taken[t]), 32'(ds_tk));
    chk("R4", "dsq",   32'(a_dsq[t]), 32'(ds_dsq));
    chk("R4", "restart", a_pc[t*PW +: PW], ds_rs);
    chk("R5", "nd_taken", 32'(b_taken[t]), 32'(nd_tk));
    chk("R5", "nd_restart", b_pc[t*PW +: PW], npc);
    chk("R5", "nd_dsq", 32'(b_dsq[t]), 0);
    clear_in();
    @(negedge clk);
    check_idle("R11", t);
  endtask

  task automatic t_memord();
    @(negedge clk);
    clear_in();
    mo_vld[1] = 1'b1; mo_seq[SW +: SW] = 16'h0077; mo_npc[PW +: PW] = 32'h0000_4444;
    exp_mo++;
    @(negedge clk);
    chk("R6", "vld",   32'(a_vld[1]), 1);
    chk("R6", "seq",   32'(a_seq[SW +: SW]), 32'h77);
    chk("R6", "restart", a_pc[PW +: PW], 32'h4444);
    chk("R6", "incl",  32'(a_incl[1]), 0);
    chk("R6", "brmis", 32'(a_brmis[1]), 0);
    chk("R6", "taken", 32'(a_taken[1]), 0);
    chk("R6", "dsq",   32'(a_dsq[1]), 0);
    chk("R6", "mispc", a_mispc[PW +: PW], 0);
    chk("R6", "ack",   32'(a_ack[1]), 0);
    chk("R9", "other_thread", 32'(a_vld[0]), 0);
    clear_in();
    @(negedge clk);
  endtask

  task automatic t_ldblk();
    @(negedge clk);
    clear_in();
    lb_vld[0] = 1'b1; lb_seq[0 +: SW] = 16'h0099; lb_pc[0 +: PW] = 32'h0000_5000;
    @(negedge clk);
    chk("R7", "vld",  32'(a_vld[0]), 1);
    chk("R7", "incl", 32'(a_incl[0]), 1);
    chk("R7", "seq",  32'(a_seq[0 +: SW]), 32'h99);
    chk("R7", "restart", a_pc[0 +: PW], 32'h5000);
    chk("R7", "ack",  32'(a_ack[0]), 1);
    chk("R7", "brmis", 32'(a_brmis[0]), 0);
    clear_in();
    @(negedge clk);
    chk("R7", "ack_one_cycle", 32'(a_ack[0]), 0);
    check_idle("R11", 0);
  endtask

  task automatic t_priority();
    @(negedge clk);
    clear_in();
    set_br(0, 1'b1, 16'h0011, 32'h0000_6000, 32'h0000_6004, 32'h0000_7000);
    mo_vld[0] = 1'b1; mo_seq[0 +: SW] = 16'h0012; mo_npc[0 +: PW] = 32'h0000_AAAA;
    lb_vld[0] = 1'b1; lb_seq[0 +: SW] = 16'h0013; lb_pc[0 +: PW] = 32'h0000_BBBB;
    mo_vld[1] = 1'b1; mo_seq[SW +: SW] = 16'h0021; mo_npc[PW +: PW] = 32'h0000_CCCC;
    lb_vld[1] = 1'b1; lb_seq[SW +: SW] = 16'h0022; lb_pc[PW +: PW] = 32'h0000_DDDD;
    exp_pt++; exp_mo++;
    @(negedge clk);
    chk("R8", "t0_brmis", 32'(a_brmis[0]), 1);
    chk("R8", "t0_seq",   32'(a_seq[0 +: SW]), 32'h11);
    chk("R8", "t0_restart", a_pc[0 +: PW], 32'h7000);
    chk("R8", "t0_ack",   32'(a_ack[0]), 0);
    chk("R8", "t0_incl",  32'(a_incl[0]), 0);
    chk("R8", "t1_seq",   32'(a_seq[SW +: SW]), 32'h21);
    chk("R8", "t1_restart", a_pc[PW +: PW], 32'hCCCC);
    chk("R8", "t1_ack",   32'(a_ack[1]), 0);
    chk("R8", "t1_brmis", 32'(a_brmis[1]), 0);
    clear_in();
    @(negedge clk);
    check_cnt("R8");
  endtask

  task automatic t_threads();
    @(negedge clk);
    clear_in();
    lb_vld[0] = 1'b1; lb_seq[0 +: SW] = 16'h0031; lb_pc[0 +: PW] = 32'h0000_8000;
    set_br(1, 1'b0, 16'h0032, 32'h0000_9000, 32'h0000_9100, 32'h0000_9104);
    exp_pnt++;
    @(negedge clk);
    chk("R9", "t0_ack",  32'(a_ack[0]), 1);
    chk("R9", "t0_restart", a_pc[0 +: PW], 32'h8000);
    chk("R9", "t0_brmis", 32'(a_brmis[0]), 0);
    chk("R9", "t1_brmis", 32'(a_brmis[1]), 1);
    chk("R9", "t1_ack",  32'(a_ack[1]), 0);
    chk("R9", "t1_restart", a_pc[PW +: PW], 32'h9100);
    chk("R9", "t1_dsq",  32'(a_dsq[1]), 1);
    clear_in();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
    finish_run();
  end

  initial begin
    clear_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int t = 0; t < NT; t++) check_idle("R1", t);
    check_cnt("R1");
    rst_n = 1'b1;
    @(negedge clk);
    for (int t = 0; t < NT; t++) check_idle("R1", t);
    check_cnt("R1");

    // resolved taken, delay slot kept: restart at next-next
    t_branch(0, 1'b1, 16'h0055, 32'h1000, 32'h1004, 32'h2000, 1'b1, 1'b0, 32'h2000, 1'b0);
    // next PC jumps: delay slot discarded, restart at next PC
    t_branch(0, 1'b0, 16'h0056, 32'h1000, 32'h3000, 32'h3004, 1'b1, 1'b1, 32'h3000, 1'b1);
    // next-next exactly PC+8: not taken
    t_branch(1, 1'b1, 16'h0057, 32'h1000, 32'h1004, 32'h1008, 1'b0, 1'b0, 32'h1008, 1'b0);
    // next-next exactly PC+12: not taken
    t_branch(1, 1'b0, 16'h0058, 32'h1000, 32'h1004, 32'h100C, 1'b0, 1'b0, 32'h100C, 1'b0);
    // next-next PC+16: taken
    t_branch(0, 1'b1, 16'h0059, 32'h1000, 32'h1004, 32'h1010, 1'b1, 1'b0, 32'h1010, 1'b0);

    t_memord();
    t_ldblk();
    t_priority();
    t_threads();
    @(negedge clk);
    check_cnt("R10");
    finish_run();
  end

endmodule